// File: doc/BRIEF.md
# Ethernet transmit frame assembler

The block takes 32-bit data writes from a host and collects them into a 2048-byte frame buffer. The first write of a frame is a header word. Its low half gives the payload length, which does not count the 14-byte Ethernet header. Its upper two bytes are the first two bytes of the frame. Every later write adds four bytes to the buffer.

Once the buffered byte count reaches the expected total, the frame is released on a byte stream that uses valid, ready and last. If CRC generation is off, the host also supplies a 4-byte trailer, and the block drops that trailer instead of sending it. A short frame can be extended with zero bytes up to the Ethernet minimum of 60.

Two sticky interrupt flags report the outcome: one for a rejected length and one for a frame that has been sent. An acknowledge input clears each flag. Acknowledging the error flag also sends the assembler back to waiting for a header word.

Top module: `tx_frame_asm`

## Requirements
- R1: After reset, wr_ready is 1, m_valid is 0, and both irq_txerr and irq_txemp are 0.
- R2: In a header word, wr_data[15:0] is the payload length L. wr_data[23:16] becomes frame byte 0 and wr_data[31:24] becomes frame byte 1.
- R3: Each later data write adds four frame bytes in order wr_data[7:0], [15:8], [23:16], [31:24].
- R4: A header word with L greater than 2032 sets irq_txerr and produces no output. After that, data writes are ignored until ack_txerr is asserted.
- R5: ack_txerr clears irq_txerr and returns the assembler to waiting for a header word. This also abandons a frame that is partly assembled.
- R6: With crc_gen_en set, the frame is released after L+14 bytes and exactly L+14 bytes are sent. Surplus bytes in the final write are discarded.
- R7: With crc_gen_en clear, the host supplies L+18 bytes. The last 4 are dropped, so L+14 bytes are sent.
- R8: If pad_en is set when the header word is written and L+14 < 60, zero bytes are appended to make 60 bytes. Otherwise the length is unchanged.
- R9: One byte moves per cycle in which m_valid and m_ready are both 1. m_last marks the final byte. While m_ready is 0, m_data, m_valid and m_last hold their values.
- R10: wr_ready is 0 from the release of a frame until its last byte is accepted. Writes made while wr_ready is 0 are not taken.
- R11: irq_txemp is set when the last byte of a frame is accepted and cleared by ack_txemp. If both happen in the same cycle, the flag is set.
- R12: If a too-long header word and ack_txerr arrive in the same cycle, irq_txerr is set and the frame is rejected.
- R13: With L = 2032 and crc_gen_en clear, the trailer bytes that fall past the end of the buffer do not overwrite the start of the frame. All 2046 bytes are sent intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_gen_en | input | 1 | CRC generated downstream; no trailer is expected from the host (sampled with the header word) |
| pad_en | input | 1 | Pad short frames to 60 bytes (sampled with the header word) |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 32 | Data write value |
| wr_ready | output | 1 | Write can be taken this cycle |
| ack_txerr | input | 1 | Acknowledge the error flag and reset the assembler |
| ack_txemp | input | 1 | Acknowledge the frame-sent flag |
| irq_txerr | output | 1 | Length-rejected flag |
| irq_txemp | output | 1 | Frame-sent flag |
| m_data | output | 8 | Stream byte |
| m_valid | output | 1 | Stream byte valid |
| m_last | output | 1 | Final byte of the frame |
| m_ready | input | 1 | Downstream accepts the byte |

## Verification
Each flag can be set and acknowledged in the same cycle. For the frame-sent flag, the bench holds ack_txemp high across the edge that accepts the last byte, then checks that irq_txemp reads 1 afterwards. For the error flag, the bench drives a too-long header word together with ack_txerr. It expects irq_txerr to remain set, and expects a later valid frame to go through only after a separate acknowledge.

// File: rtl/txa_pkg.sv
package txa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FILL     = 2'd1,
    ST_DRAIN    = 2'd2,
    ST_HOLD_ERR = 2'd3
  } asm_st_t;

  localparam int HDR_BYTES = 14;
  localparam int FCS_BYTES = 4;
  localparam int MIN_FRAME = 60;
  localparam int LANES     = 4;
endpackage

// File: rtl/txa_lane_ram.sv
module txa_lane_ram #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txa_fill.sv
module txa_fill
  import txa_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int MAX_LEN = 2032,
  localparam int LAW    = $clog2(DEPTH / LANES),
  localparam int PTR_W  = $clog2(DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      crc_gen_en,
  input  logic                      pad_en,
  input  logic                      wr_en,
  input  logic [31:0]               wr_data,
  input  logic                      ack_txerr,
  input  logic                      drain_done,
  output logic                      wr_ready,
  output logic [LANES-1:0]          lane_we,
  output logic [LANES-1:0][LAW-1:0] lane_waddr,
  output logic [LANES-1:0][7:0]     lane_wdata,
  output logic                      start,
  output logic [PTR_W-1:0]          tot_len,
  output logic [PTR_W-1:0]          dat_len,
  output logic                      irq_txerr
);
  localparam int LEN_W = 16;

  asm_st_t          st;
  logic [PTR_W-1:0] ptr, exp_cnt, dlen;
  logic             pad_q;

  logic [LEN_W-1:0] len_in;
  logic             too_long, take, go, err_set;
  logic [PTR_W-1:0] ptr_nx, base;
  logic [2:0]       nbytes;
  logic [LANES-1:0][7:0]       bsel;
  logic [LANES-1:0][1:0]       jx;
  logic [LANES-1:0][PTR_W-1:0] ax;

  assign len_in   = wr_data[LEN_W-1:0];
  assign too_long = len_in > LEN_W'(MAX_LEN);
  assign wr_ready = (st != ST_DRAIN);
  // an acknowledge during assembly wins over a write in the same cycle
  assign take     = wr_en && wr_ready && !(ack_txerr && st == ST_FILL);
  assign ptr_nx   = ptr + PTR_W'(LANES);
  assign err_set  = take && (st == ST_IDLE) && too_long;
  assign start    = take && (st == ST_FILL) && (ptr_nx >= exp_cnt);
  assign dat_len  = dlen;
  assign tot_len  = (pad_q && dlen < PTR_W'(MIN_FRAME)) ? PTR_W'(MIN_FRAME) : dlen;

  // byte steering into the four lanes
  always_comb begin
    base   = '0;
    nbytes = 3'd0;
    bsel   = '0;
    go     = 1'b0;
    if (st == ST_IDLE) begin
      nbytes  = 3'd2;
      bsel[0] = wr_data[23:16];
      bsel[1] = wr_data[31:24];
      go      = take && !too_long;
    end else if (st == ST_FILL) begin
      base   = ptr;
      nbytes = 3'd4;
      bsel   = wr_data;
      go     = take;
    end
    for (int l = 0; l < LANES; l++) begin
      jx[l]         = 2'(l) - base[1:0];
      ax[l]         = base + PTR_W'(jx[l]);
      lane_we[l]    = go && ({1'b0, jx[l]} < nbytes) && (ax[l] < PTR_W'(DEPTH));
      lane_waddr[l] = LAW'(ax[l] >> 2);
      lane_wdata[l] = bsel[jx[l]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      exp_cnt   <= '0;
      dlen      <= '0;
      pad_q     <= 1'b0;
      irq_txerr <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          if (too_long) st <= ST_HOLD_ERR;
          else begin
            st      <= ST_FILL;
            ptr     <= PTR_W'(2);
            dlen    <= PTR_W'(len_in) + PTR_W'(HDR_BYTES);
            exp_cnt <= PTR_W'(len_in) + PTR_W'(HDR_BYTES)
                       + (crc_gen_en ? PTR_W'(0) : PTR_W'(FCS_BYTES));
            pad_q   <= pad_en;
          end
        end
        ST_FILL: if (take) begin
          ptr <= ptr_nx;
          if (ptr_nx >= exp_cnt) st <= ST_DRAIN;
        end
        ST_DRAIN: if (drain_done) st <= ST_IDLE;
        default: ;
      endcase
      if (ack_txerr && st != ST_DRAIN && !err_set) st <= ST_IDLE;
      if (ack_txerr) irq_txerr <= 1'b0;
      if (err_set)   irq_txerr <= 1'b1;
    end
  end

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_txerr) |-> $past(wr_en && wr_data[LEN_W-1:0] > LEN_W'(MAX_LEN)));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_txerr && !ack_txerr) |=> irq_txerr);
  // R4
  err_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD_ERR) |-> (lane_we == '0) && !start);
endmodule

// File: rtl/txa_drain.sv
module txa_drain
  import txa_pkg::*;
#(
  parameter int DEPTH  = 2048,
  localparam int LAW   = $clog2(DEPTH / LANES),
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [PTR_W-1:0]      tot_len,
  input  logic [PTR_W-1:0]      dat_len,
  input  logic                  m_ready,
  input  logic [LANES-1:0][7:0] lane_q,
  output logic                  rd_en,
  output logic [LAW-1:0]        rd_waddr,
  output logic [7:0]            m_data,
  output logic                  m_valid,
  output logic                  m_last,
  output logic                  done
);
  logic             active, zsel;
  logic [1:0]       lane_sel;
  logic [PTR_W-1:0] rd_idx, tot_q, dlen_q;
  logic             adv;

  assign adv      = !m_valid || m_ready;
  assign rd_en    = active && adv && (rd_idx < tot_q);
  assign rd_waddr = LAW'(rd_idx >> 2);
  assign done     = m_valid && m_ready && m_last;
  assign m_data   = zsel ? 8'h00 : lane_q[lane_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rd_idx   <= '0;
      tot_q    <= '0;
      dlen_q   <= '0;
      m_valid  <= 1'b0;
      m_last   <= 1'b0;
      zsel     <= 1'b0;
      lane_sel <= '0;
    end else begin
      if (start) begin
        active <= 1'b1;
        rd_idx <= '0;
        tot_q  <= tot_len;
        dlen_q <= dat_len;
      end else if (adv) begin
        if (rd_en) begin
          m_valid  <= 1'b1;
          m_last   <= (rd_idx == tot_q - PTR_W'(1));
          zsel     <= (rd_idx >= dlen_q);
          lane_sel <= rd_idx[1:0];
          rd_idx   <= rd_idx + PTR_W'(1);
        end else begin
          m_valid <= 1'b0;
          m_last  <= 1'b0;
        end
      end
      if (done) active <= 1'b0;
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_last));
  // R9
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm
  import txa_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int MAX_LEN = 2032
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        crc_gen_en,
  input  logic        pad_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  input  logic        ack_txerr,
  input  logic        ack_txemp,
  output logic        irq_txerr,
  output logic        irq_txemp,
  output logic [7:0]  m_data,
  output logic        m_valid,
  output logic        m_last,
  input  logic        m_ready
);
  localparam int LAW   = $clog2(DEPTH / LANES);
  localparam int PTR_W = $clog2(DEPTH) + 1;

  logic [LANES-1:0]          lane_we;
  logic [LANES-1:0][LAW-1:0] lane_waddr;
  logic [LANES-1:0][7:0]     lane_wdata, lane_q;
  logic                      start, done, rd_en;
  logic [PTR_W-1:0]          tot_len, dat_len;
  logic [LAW-1:0]            rd_waddr;

  txa_fill #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_fill (
    .clk, .rst, .crc_gen_en, .pad_en, .wr_en, .wr_data, .ack_txerr,
    .drain_done(done), .wr_ready, .lane_we, .lane_waddr, .lane_wdata,
    .start, .tot_len, .dat_len, .irq_txerr
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    txa_lane_ram #(.AW(LAW)) u_ram (
      .clk, .we(lane_we[g]), .waddr(lane_waddr[g]), .wdata(lane_wdata[g]),
      .re(rd_en), .raddr(rd_waddr), .rdata(lane_q[g])
    );
  end

  txa_drain #(.DEPTH(DEPTH)) u_drain (
    .clk, .rst, .start, .tot_len, .dat_len, .m_ready, .lane_q,
    .rd_en, .rd_waddr, .m_data, .m_valid, .m_last, .done
  );

  always_ff @(posedge clk) begin
    if (rst) irq_txemp <= 1'b0;
    else begin
      if (ack_txemp) irq_txemp <= 1'b0;
      if (done)      irq_txemp <= 1'b1;
    end
  end

  // R11
  txemp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_txemp) |-> $past(m_valid && m_ready && m_last));
  // R10
  stall_while_drain_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !wr_ready);
endmodule

// File: tb/sim_tx_frame_asm.sv
module sim_tx_frame_asm;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {length[15:0], crc_gen_en, pad_en, stall}
  localparam logic [18:0] VEC [NVEC] = '{
    {16'd46,   1'b1, 1'b0, 1'b0},   // R6 exactly 60
    {16'd10,   1'b1, 1'b1, 1'b0},   // R8 pad to 60
    {16'd10,   1'b0, 1'b0, 1'b0},   // R7 trailer dropped
    {16'd0,    1'b0, 1'b1, 1'b1},   // R8 header only, padded
    {16'd100,  1'b0, 1'b1, 1'b1},   // R8 no pad at >=60
    {16'd45,   1'b1, 1'b1, 1'b0},   // R8 one pad byte
    {16'd2032, 1'b1, 1'b0, 1'b0},   // R6 longest
    {16'd2032, 1'b0, 1'b0, 1'b1},   // R13 trailer past buffer end
    {16'd7,    1'b1, 1'b0, 1'b0}    // R6 surplus bytes in last word
  };

  logic clk = 0, rst = 1;
  logic crc_gen_en = 0, pad_en = 0, wr_en = 0, ack_txerr = 0, ack_txemp = 0, m_ready = 0;
  logic [31:0] wr_data = '0;
  logic wr_ready, irq_txerr, irq_txemp, m_valid, m_last;
  logic [7:0] m_data;
  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] cap [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_asm u0 (.*);

  function automatic logic [7:0] pb(int k, int p);
    return 8'(p * 5 + k * 37 + (p >> 6) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put_word(input logic [31:0] d, input bit with_ack);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1; wr_data = d; ack_txerr = with_ack;
    @(negedge clk);
    wr_en = 0; ack_txerr = 0;
  endtask

  task automatic pulse_ack_err();
    @(negedge clk); ack_txerr = 1;
    @(negedge clk); ack_txerr = 0;
  endtask

  task automatic run_frame(input int k, input int len, input bit crc, input bit pad,
                           input bit stall, input bit ackemp);
    int s, e, outl, got, errs, stab, cyc;
    bit fin, hold;
    logic [7:0] held;
    string tg;
    s = len + 14;
    e = s + (crc ? 0 : 4);
    outl = (pad && s < 60) ? 60 : s;
    @(negedge clk);
    crc_gen_en = crc; pad_en = pad;
    put_word({pb(k, 1), pb(k, 0), 16'(len)}, 0);
    for (int p = 2; p < e; p += 4)
      put_word({pb(k, p + 3), pb(k, p + 2), pb(k, p + 1), pb(k, p)}, 0);
    chk(wr_ready == 0, "R10 wr_ready during drain", int'(wr_ready), 0);
    got = 0; errs = 0; stab = 0; cyc = 0; fin = 0; hold = 0; held = '0;
    while (!fin && cyc < 4 * outl + 50) begin
      @(negedge clk);
      cyc++;
      ack_txemp = 0;
      if (hold && (!m_valid || m_data != held)) stab++;
      m_ready = stall ? (cyc % 3 != 0) : 1'b1;
      hold = m_valid && !m_ready;
      held = m_data;
      if (m_valid && m_ready) begin
        if (got < 4096) cap[got] = m_data;
        got++;
        if (m_last) begin
          fin = 1;
          if (ackemp) ack_txemp = 1;
        end
      end
    end
    @(negedge clk);
    m_ready = 0; ack_txemp = 0;
    for (int i = 0; i < got && i < outl; i++)
      if (cap[i] !== ((i < s) ? pb(k, i) : 8'h00)) errs++;
    if (len == 2032 && !crc) tg = "R13 length";
    else if (pad) tg = "R8 length";
    else if (crc) tg = "R6 length";
    else tg = "R7 length";
    chk(got == outl, tg, got, outl);
    chk(errs == 0, "R2 R3 byte content", errs, 0);
    if (stall) chk(stab == 0, "R9 hold under stall", stab, 0);
    chk(irq_txemp == 1, ackemp ? "R11 set beats ack" : "R11 flag set", int'(irq_txemp), 1);
    chk(wr_ready == 1, "R10 ready after frame", int'(wr_ready), 1);
    @(negedge clk); ack_txemp = 1;
    @(negedge clk); ack_txemp = 0;
    chk(irq_txemp == 0, "R11 ack clears", int'(irq_txemp), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    chk(m_valid == 0, "R1 m_valid", int'(m_valid), 0);
    chk(irq_txerr == 0 && irq_txemp == 0, "R1 flags", int'({irq_txerr, irq_txemp}), 0);

    for (int i = 0; i < NVEC; i++)
      run_frame(i, int'(VEC[i][18:3]), VEC[i][2], VEC[i][1], VEC[i][0], 1'b0);

    // R4: too-long length rejected, later words ignored
    put_word({16'hBEEF, 16'd2033}, 0);
    chk(irq_txerr == 1, "R4 error flag", int'(irq_txerr), 1);
    put_word(32'h0000_0010, 0);
    put_word(32'h1111_2222, 0);
    put_word(32'h3333_4444, 0);
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (m_valid) seen++;
    end
    chk(seen == 0, "R4 no output", seen, 0);
    // R5: acknowledge clears and re-arms
    pulse_ack_err();
    chk(irq_txerr == 0, "R5 ack clears", int'(irq_txerr), 0);
    run_frame(20, 20, 1'b1, 1'b0, 1'b0, 1'b0);

    // R5: abort a partly assembled frame
    crc_gen_en = 1; pad_en = 0;
    put_word({16'h0102, 16'd50}, 0);
    put_word(32'hAAAA_AAAA, 0);
    put_word(32'hBBBB_BBBB, 0);
    pulse_ack_err();
    run_frame(21, 30, 1'b1, 1'b1, 1'b1, 1'b0);

    // R12: too-long header with simultaneous acknowledge
    put_word({16'h0000, 16'd4000}, 1);
    chk(irq_txerr == 1, "R12 set beats ack", int'(irq_txerr), 1);
    put_word(32'h0000_0020, 0);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (m_valid) seen++;
    end
    chk(seen == 0, "R12 frame rejected", seen, 0);
    pulse_ack_err();
    chk(irq_txerr == 0, "R12 later ack clears", int'(irq_txerr), 0);

    // R11: last byte accepted in the same cycle as ack_txemp
    run_frame(22, 40, 1'b0, 1'b0, 1'b0, 1'b1);

    finish_run();
  end
endmodule